// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Character Queue

This block takes an idle-high asynchronous serial line and turns each frame into a character. A frame is one low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one stop bit. The block measures time in oversample ticks, sixteen to a bit. An internal divider makes these ticks from the core clock. The line passes through a two-flop synchronizer. A start edge is accepted only if the line is still low at the middle of the start bit. Each data bit is then sampled once at its middle.

Each finished character is written into a small queue, two entries deep by default, together with a flag that says whether its stop bit was low. The host reads the oldest entry from `head_data` and `head_ferr` and removes it by pulsing `pop`. The interrupt line `rx_irq` is high for as long as the queue holds at least one entry. If a character finishes while the queue is full, that character is dropped and a sticky overrun condition is raised. The overrun halts reception until `rx_en` is taken low. In nine-bit mode an address filter can be enabled, so that only frames whose ninth bit is 1 are kept.

The frame state machine has these states:
- `S_IDLE`: waits for a low line on a tick.
- `S_START`: checks the start bit at its middle.
- `S_DATA`: shifts in eight bits.
- `S_NINTH`: samples the ninth bit.
- `S_STOP`: samples the stop bit and commits the character.
- `S_RECOVER`: after a low stop bit, waits for the line to return high.
- `S_HALT`: the overrun state.

Its transitions are:
- IDLE→START on a low line.
- START→IDLE if the start bit was a glitch.
- START→DATA if the start bit is confirmed.
- DATA→NINTH or DATA→STOP after bit 7, depending on the mode.
- NINTH→STOP.
- STOP→IDLE, STOP→RECOVER or STOP→HALT.
- RECOVER→IDLE once the line is high.
- Any state→IDLE while `rx_en` is low.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the queue is empty, `rx_irq` and `overrun` are low, and `head_data` and `head_ferr` read 0.
- R2: In 8-bit mode (`nine_bit`=0) the eight data bits arrive least significant bit first and appear in `head_data[7:0]`, with `head_data[8]`=0.
- R3: In 9-bit mode (`nine_bit`=1) the bit that follows the eight data bits appears in `head_data[8]`.
- R4: A low pulse on `rx_line` shorter than half a bit is not accepted as a start bit, and no character is produced.
- R5: `head_ferr` is 1 exactly when the stop bit of the entry now at the head was sampled low. The flag belongs to each entry separately.
- R6: The queue holds two characters in arrival order. A `pop` while the queue is not empty removes the head, and the next entry takes its place.
- R7: A character that finishes while the queue is full is discarded and sets `overrun`. While `overrun` is set, all further frames are ignored. Setting `rx_en` low clears `overrun` and leaves the stored entries in place.
- R8: With `addr_only`=1 in 9-bit mode, frames whose ninth bit is 0 are dropped. In 8-bit mode `addr_only` has no effect.
- R9: `rx_irq` is high exactly while the queue holds at least one entry.
- R10: While `rx_en` is low, activity on `rx_line` produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; taking it low clears overrun |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| addr_only | input | 1 | 1 keeps only frames whose ninth bit is 1 (9-bit mode only) |
| rx_line | input | 1 | Serial input line, idle high |
| pop | input | 1 | Removes the head entry from the queue |
| head_data | output | 9 | Head entry data; bit 8 is the ninth bit |
| head_ferr | output | 1 | Stop bit of the head entry was low |
| rx_irq | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky overrun; reception is halted |

## Verification
The bench builds the block with a tick divider of 3, which gives 48 clocks per bit, keeps sixteen ticks per bit, and uses a queue depth of two. A frame therefore takes only about 600 clocks, so several dozen random frames fit in the run. The random frames mix modes, the address filter, bad stop bits and pops. With only two entries, the queue fills, overruns, and drains between pops many times. The short bit time also makes it cheap to send a low pulse shorter than half a bit, which checks glitch rejection.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int unsigned CHAR_BITS = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_NINTH,
        S_STOP,
        S_RECOVER,
        S_HALT
    } rx_state_t;

    typedef struct packed {
        logic       ferr;
        logic [8:0] data;
    } rx_entry_t;
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);

    // ticks never come back to back when the divider is above one
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((DIV > 1) && tick) |=> !tick);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] CAP = (AW + 1)'(DEPTH);

    rx_entry_t   mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CAP);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else if (do_push && wr_q == AW'(g)) begin
                    mem_q[g] <= push_entry;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= bump(wr_q);
            end
            if (do_pop) begin
                rd_q <= bump(rd_q);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head = empty ? '0 : mem_q[rd_q];

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);
    p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_pop_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && !do_push) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_en,
    input  logic      nine_bit,
    input  logic      addr_only,
    input  logic      tick,
    input  logic      rx_s,
    input  logic      fifo_full,
    output logic      push,
    output rx_entry_t push_entry,
    output logic      overrun
);
    localparam int unsigned CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam int unsigned BW = $clog2(CHAR_BITS);

    rx_state_t state_q, state_d;
    logic [CW-1:0]        cnt_q;
    logic [BW-1:0]        bit_q;
    logic [CHAR_BITS-1:0] shreg_q;
    logic                 ninth_q;
    logic                 mid_start, bit_end, stop_end, keep;

    assign mid_start = tick && (cnt_q == MID);
    assign bit_end   = tick && (cnt_q == LAST);
    assign stop_end  = (state_q == S_STOP) && bit_end;
    assign keep      = !(addr_only && nine_bit && !ninth_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (tick && !rx_s) state_d = S_START;
            end
            S_START: begin
                if (mid_start) state_d = rx_s ? S_IDLE : S_DATA;
            end
            S_DATA: begin
                if (bit_end && bit_q == BW'(CHAR_BITS - 1)) begin
                    state_d = nine_bit ? S_NINTH : S_STOP;
                end
            end
            S_NINTH: begin
                if (bit_end) state_d = S_STOP;
            end
            S_STOP: begin
                if (bit_end) begin
                    if (keep && fifo_full) state_d = S_HALT;
                    else                   state_d = rx_s ? S_IDLE : S_RECOVER;
                end
            end
            S_RECOVER: begin
                if (rx_s) state_d = S_IDLE;
            end
            S_HALT: begin
                state_d = S_HALT;
            end
            default: state_d = S_IDLE;
        endcase
        if (!rx_en) state_d = S_IDLE;
    end

    // sample counter, bit index and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            ninth_q <= 1'b0;
        end else if (!rx_en) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else if (tick) begin
            unique case (state_q)
                S_START: begin
                    cnt_q <= (cnt_q == MID) ? '0 : cnt_q + 1'b1;
                    bit_q <= '0;
                end
                S_DATA: begin
                    if (cnt_q == LAST) begin
                        cnt_q   <= '0;
                        shreg_q <= {rx_s, shreg_q[CHAR_BITS-1:1]};
                        bit_q   <= bit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_NINTH: begin
                    if (cnt_q == LAST) ninth_q <= rx_s;
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
                S_STOP: begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        push            = rx_en && stop_end && keep && !fifo_full;
        push_entry.ferr = !rx_s;
        push_entry.data = {nine_bit ? ninth_q : 1'b0, shreg_q};
        overrun         = (state_q == S_HALT);
    end

    p_ninth_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !nine_bit) |-> !push_entry.data[8]);
    p_addr_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && nine_bit && addr_only) |-> push_entry.data[8]);
    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en) |=> overrun);
    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == S_IDLE));
    p_push_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (state_q == S_STOP));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int unsigned TICK_DIV = 4,
    parameter int unsigned OVS      = 16,
    parameter int unsigned DEPTH    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       addr_only,
    input  logic       rx_line,
    input  logic       pop,
    output logic [8:0] head_data,
    output logic       head_ferr,
    output logic       rx_irq,
    output logic       overrun
);
    logic      tick, rx_s, sync_a, push, fifo_full, fifo_empty;
    rx_entry_t push_entry, head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            rx_s   <= 1'b1;
        end else begin
            sync_a <= rx_line;
            rx_s   <= sync_a;
        end
    end

    srx_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .tick  (tick)
    );

    srx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .nine_bit   (nine_bit),
        .addr_only  (addr_only),
        .tick       (tick),
        .rx_s       (rx_s),
        .fifo_full  (fifo_full),
        .push       (push),
        .push_entry (push_entry),
        .overrun    (overrun)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .empty      (fifo_empty),
        .full       (fifo_full)
    );

    assign head_data = head.data;
    assign head_ferr = head.ferr;
    assign rx_irq    = !fifo_empty;

    // an interrupt raised by a push stays up while nothing pops
    p_irq_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !pop) |=> rx_irq);
endmodule

// File: tb/test_serial_rx_core.sv
`timescale 1ns/1ps
module test_serial_rx_core;
    localparam int DIV = 3;
    localparam int BIT = 16 * DIV;

    logic clk = 0, rst_n = 0, rx_en = 0, nine_bit = 0, addr_only = 0, rx_line = 1, pop = 0;
    logic [8:0] head_data;
    logic head_ferr, rx_irq, overrun;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [9:0] mq[$];
    bit m_ovr = 0;

    always #2 clk = ~clk;

    serial_rx_core #(.TICK_DIV(DIV), .OVS(16), .DEPTH(2)) i_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .nine_bit(nine_bit),
        .addr_only(addr_only), .rx_line(rx_line), .pop(pop),
        .head_data(head_data), .head_ferr(head_ferr), .rx_irq(rx_irq), .overrun(overrun)
    );

    task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_entry(input logic [8:0] d, input bit nine, input bit stop);
        return {~stop, nine ? d[8] : 1'b0, d[7:0]};
    endfunction

    task automatic model_frame(input logic [8:0] d, input bit nine, input bit addr, input bit stop);
        if (!rx_en || m_ovr) return;
        if (addr && nine && !d[8]) return;
        if (mq.size() == 2) m_ovr = 1;
        else mq.push_back(exp_entry(d, nine, stop));
    endtask

    task automatic send(input logic [8:0] d, input bit nine, input bit addr, input bit stop);
        @(negedge clk);
        nine_bit = nine; addr_only = addr;
        rx_line = 0; repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i]; repeat (BIT) @(negedge clk);
        end
        if (nine) begin
            rx_line = d[8]; repeat (BIT) @(negedge clk);
        end
        rx_line = stop; repeat (BIT) @(negedge clk);
        rx_line = 1; repeat (BIT) @(negedge clk);
        model_frame(d, nine, addr, stop);
    endtask

    task automatic check_all(input string req);
        chk(rx_irq == (mq.size() != 0), {req, "/R9 irq"}, rx_irq, mq.size() != 0);
        chk(overrun == m_ovr, {req, " overrun"}, overrun, m_ovr);
        if (mq.size() != 0)
            chk({head_ferr, head_data} == mq[0], {req, " head"}, {head_ferr, head_data}, mq[0]);
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1;
        @(negedge clk) pop = 0;
        if (mq.size() != 0) void'(mq.pop_front());
    endtask

    task automatic toggle_en();
        @(negedge clk) rx_en = 0;
        repeat (4) @(negedge clk);
        rx_en = 1; m_ovr = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!rx_irq && !overrun && head_data == 0 && !head_ferr, "R1 reset",
            {rx_irq, overrun, head_ferr, head_data}, 0);
        rx_en = 1;
        repeat (8) @(negedge clk);

        // R2 8-bit LSB first
        send(9'h0A5, 0, 0, 1); check_all("R2 8-bit");
        chk(head_data == 9'h0A5, "R2 value", head_data, 9'h0A5);
        do_pop(); check_all("R6 pop empty");

        // R3 ninth bit
        send(9'h13C, 1, 0, 1); check_all("R3 ninth");
        chk(head_data[8] == 1, "R3 bit8", head_data[8], 1);
        do_pop();

        // R4 short glitch
        @(negedge clk) rx_line = 0;
        repeat (5 * DIV) @(negedge clk);
        rx_line = 1;
        repeat (2 * BIT) @(negedge clk);
        chk(!rx_irq, "R4 glitch", rx_irq, 0);

        // R5 framing error per entry
        send(9'h055, 0, 0, 0); send(9'h0C3, 0, 0, 1);
        check_all("R5 ferr head");
        do_pop(); check_all("R5 clean second"); do_pop();

        // R6 order
        send(9'h011, 0, 0, 1); send(9'h022, 0, 0, 1);
        check_all("R6 first"); do_pop(); check_all("R6 second"); do_pop();

        // R7 overrun
        send(9'h031, 0, 0, 1); send(9'h032, 0, 0, 1); send(9'h033, 0, 0, 1);
        check_all("R7 overrun set");
        send(9'h034, 0, 0, 1); check_all("R7 halted");
        toggle_en(); check_all("R7 cleared kept");
        do_pop(); check_all("R7 second kept"); do_pop();

        // R8 address filter
        send(9'h077, 1, 1, 1); check_all("R8 drop ninth0");
        send(9'h178, 1, 1, 1); check_all("R8 keep ninth1"); do_pop();
        send(9'h079, 0, 1, 1); check_all("R8 8-bit ignores filter"); do_pop();

        // R10 disabled
        @(negedge clk) rx_en = 0;
        send(9'h0EE, 0, 0, 1); check_all("R10 disabled");
        rx_en = 1; repeat (8) @(negedge clk);

        // random mix
        void'($urandom(32'd20240611));
        for (int n = 0; n < 48; n++) begin
            logic [8:0] d;
            bit nine, addr, stop;
            d    = 9'($urandom);
            nine = 1'($urandom);
            addr = ($urandom % 4) == 0;
            stop = ($urandom % 8) != 0;
            send(d, nine, addr, stop);
            check_all("R9 random");
            if (m_ovr) begin
                toggle_en(); check_all("R7 random clear");
            end
            if ($urandom % 2) begin
                do_pop(); check_all("R6 random pop");
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule